// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset-Cause Flags

This block is a watchdog counter that runs on a slow, dedicated clock. Firmware must restart it regularly, either with a clear strobe or by halting. If the count reaches the selected time-out, the block resets the device. Which reset it produces depends on the power state. In run mode it pulses a full device reset. In sleep or idle mode it pulses only a light reset, which returns the program counter and stack pointer to their start values. In both cases it sets a sticky time-out status bit.

A 5-bit key field in the control register controls the watchdog. One code enables it, a second code disables it, and every other code is treated as a software reset request. A software reset request clears the count, waits a fixed number of cycles, then pulses the full reset and sets a sticky cause flag. Software can clear that flag but cannot set it.

A 3-bit field selects the time-out as a power-of-two number of watchdog clock cycles. The flag register also holds a low-voltage reset flag. The block keeps that flag but does not otherwise use it.

Top module: `wdt_keyguard`

## Requirements
- R1: The control register reads as `{key[4:0], ratio[2:0]}` on `rd_ctrl[7:3]` and `rd_ctrl[2:0]`. After power-up it reads 0x50 (key 01010b, ratio 0), and the watchdog counts.
- R2: Writing key 10101b disables the watchdog. The count is held at zero, and no reset is produced for as long as that key stays in place.
- R3: Writing any key other than 01010b or 10101b clears the count. `dev_rst` then rises exactly SRST_DLY clock edges after the write edge (4 by default). Control writes made while this delay is pending are ignored.
- R4: The flag register reads `{5'b0, lvr_flag, 1'b0, swr_flag}`. The software-reset flag at bit 0 is set by a key-triggered reset. A write of 0 to bit 0 clears it, and a write of 1 has no effect. Bit 2 is an ordinary read/write bit, and the other bits read 0.
- R5: In run mode (`low_power` = 0), `dev_rst` pulses high for one cycle and `to_flag` is set. This happens 2^(8+ratio) clock edges after the most recent clear of the count.
- R6: With `low_power` = 1, an expired count pulses `light_rst` for one cycle and sets `to_flag`, and `dev_rst` stays low.
- R7: `clr_stb` and `halt_stb` each return the count to zero and clear `to_flag`.
- R8: A ratio field value n selects a time-out of 2^(8+n) cycles, for n from 0 to 7.
- R9: On the edge that raises a full reset, the count is cleared and the control register reloads 0x50. The software-reset flag and `to_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control register, 1 = flag register |
| wr_data | input | 8 | Write data |
| clr_stb | input | 1 | Clear-watchdog instruction strobe |
| halt_stb | input | 1 | Halt instruction strobe |
| low_power | input | 1 | CPU is in sleep or idle mode |
| dev_rst | output | 1 | One-cycle full device reset |
| light_rst | output | 1 | One-cycle program counter and stack reset |
| to_flag | output | 1 | Time-out status bit |
| rd_ctrl | output | 8 | Control register value |
| rd_flags | output | 8 | Reset-flag register value |

## Verification
The counter is exercised several ways, and each test pins down one thing. Runs with no intervention fix the exact expiry edge. A clear strobe, and separately a halt strobe, are issued mid-count, and the moved expiry edge shows that each one restarts the count. A larger ratio code checks the power-of-two scaling, and a disable/re-enable sequence shows that the disable code really holds the count.

An illegal key is written, and then a second write is attempted during the pending delay. This checks the exact delay length, that the second write is ignored, and that the cause flag is set. The same expiry is then repeated in low-power mode, which separates the light reset from the full reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W    = 5;
  localparam int RATIO_W  = 3;
  localparam int BASE_EXP = 8;
  localparam int CNT_W    = BASE_EXP + (1 << RATIO_W) - 1;

  localparam logic [KEY_W-1:0] KEY_ON  = 5'b01010;
  localparam logic [KEY_W-1:0] KEY_OFF = 5'b10101;
  localparam logic [7:0]       CTRL_INIT = {KEY_ON, 3'b000};

  typedef enum logic [1:0] {KEY_RUN, KEY_STOP, KEY_ILLEGAL} key_kind_e;

  function automatic key_kind_e classify_key(input logic [KEY_W-1:0] k);
    if (k == KEY_ON)       return KEY_RUN;
    else if (k == KEY_OFF) return KEY_STOP;
    else                   return KEY_ILLEGAL;
  endfunction

  // Terminal count for ratio r: 2^(BASE_EXP+r) - 1
  function automatic logic [CNT_W-1:0] last_count(input logic [RATIO_W-1:0] r);
    logic [CNT_W:0] one;
    logic [CNT_W:0] v;
    one = 1;
    v   = (one << (BASE_EXP + int'(r))) - 1'b1;
    return v[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/wdt_keyctl.sv
module wdt_keyctl
  import wdt_pkg::*;
#(
  parameter int SRST_DLY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic [7:0]         wr_data,
  input  logic               full_rst_now,
  output logic [KEY_W-1:0]   key,
  output logic [RATIO_W-1:0] ratio,
  output logic               run_en,
  output logic               pending,
  output logic               bad_wr,
  output logic               fire
);
  localparam int DLY_W = $clog2(SRST_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SRST_DLY);

  logic [DLY_W-1:0] dly_q;

  assign pending = (dly_q != '0);
  assign fire    = (dly_q == DLY_W'(1));
  assign bad_wr  = wr_ctrl && !pending &&
                   (classify_key(wr_data[7:3]) == KEY_ILLEGAL);
  assign run_en  = !pending && (classify_key(key) == KEY_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key   <= CTRL_INIT[7:3];
      ratio <= CTRL_INIT[2:0];
      dly_q <= '0;
    end else if (full_rst_now) begin
      key   <= CTRL_INIT[7:3];
      ratio <= CTRL_INIT[2:0];
      dly_q <= '0;
    end else begin
      if (wr_ctrl && !pending) begin
        key   <= wr_data[7:3];
        ratio <= wr_data[2:0];
      end
      if (bad_wr)       dly_q <= DLY_LOAD;
      else if (pending) dly_q <= dly_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               clr,
  input  logic [RATIO_W-1:0] ratio,
  output logic [CNT_W-1:0]   cnt,
  output logic               ovf
);
  logic [CNT_W-1:0] limit;

  assign limit = last_count(ratio);
  assign ovf   = run_en && !clr && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr || ovf || !run_en) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_flags,
  input  logic wr_bit0,
  input  logic wr_bit2,
  input  logic sw_rst_set,
  input  logic to_set,
  input  logic to_clr,
  output logic swr_flag,
  output logic lvr_flag,
  output logic to_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swr_flag <= 1'b0;
      lvr_flag <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      if (sw_rst_set)                swr_flag <= 1'b1;
      else if (wr_flags && !wr_bit0) swr_flag <= 1'b0;
      if (wr_flags) lvr_flag <= wr_bit2;
      if (to_clr)      to_flag <= 1'b0;
      else if (to_set) to_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
  import wdt_pkg::*;
#(
  parameter int SRST_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       clr_stb,
  input  logic       halt_stb,
  input  logic       low_power,
  output logic       dev_rst,
  output logic       light_rst,
  output logic       to_flag,
  output logic [7:0] rd_ctrl,
  output logic [7:0] rd_flags
);
  logic [KEY_W-1:0]   key;
  logic [RATIO_W-1:0] ratio;
  logic [CNT_W-1:0]   cnt;
  logic run_en, pending, bad_wr, fire;
  logic ovf_evt, full_rst_now, cnt_clr, swr_flag, lvr_flag;

  assign full_rst_now = fire || (ovf_evt && !low_power);
  assign cnt_clr      = clr_stb || halt_stb || bad_wr || fire;

  wdt_keyctl #(.SRST_DLY(SRST_DLY)) u_keyctl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_en && !wr_sel), .wr_data(wr_data),
    .full_rst_now(full_rst_now), .key(key), .ratio(ratio), .run_en(run_en),
    .pending(pending), .bad_wr(bad_wr), .fire(fire)
  );

  wdt_counter u_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr(cnt_clr),
    .ratio(ratio), .cnt(cnt), .ovf(ovf_evt)
  );

  wdt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_flags(wr_en && wr_sel),
    .wr_bit0(wr_data[0]), .wr_bit2(wr_data[2]), .sw_rst_set(fire),
    .to_set(ovf_evt), .to_clr(clr_stb || halt_stb),
    .swr_flag(swr_flag), .lvr_flag(lvr_flag), .to_flag(to_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_rst   <= 1'b0;
      light_rst <= 1'b0;
    end else begin
      dev_rst   <= full_rst_now;
      light_rst <= ovf_evt && low_power;
    end
  end

  assign rd_ctrl  = {key, ratio};
  assign rd_flags = {5'b0, lvr_flag, 1'b0, swr_flag};
endmodule

// File: rtl/wdt_keyguard_chk.sv
module wdt_keyguard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       clr_stb,
  input logic       halt_stb,
  input logic       low_power,
  input logic       ovf_evt,
  input logic       pending,
  input logic       dev_rst,
  input logic       light_rst,
  input logic       to_flag,
  input logic [7:0] rd_ctrl,
  input logic [7:0] rd_flags
);
  // R5
  run_ovf_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !low_power) |=> (dev_rst && to_flag));
  // R5
  dev_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> !dev_rst);
  // R6
  sleep_light_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && low_power) |=> (light_rst && !dev_rst && to_flag));
  // R7
  clear_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb || halt_stb) |=> !to_flag);
  // R9
  reload_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |-> (rd_ctrl == 8'h50));
  // R4
  swr_only_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_flags[0]) |-> dev_rst);
  // R3
  bad_key_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !pending && wr_data[7:3] != 5'b01010 &&
     wr_data[7:3] != 5'b10101) |=> pending);
  // R4
  flag_spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags[7:3] == 5'b0) && !rd_flags[1]);
endmodule

bind wdt_keyguard wdt_keyguard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .clr_stb(clr_stb), .halt_stb(halt_stb), .low_power(low_power),
  .ovf_evt(ovf_evt), .pending(pending), .dev_rst(dev_rst),
  .light_rst(light_rst), .to_flag(to_flag), .rd_ctrl(rd_ctrl),
  .rd_flags(rd_flags)
);

// File: tb/wdt_keyguard_tb_top.sv
`timescale 1ns/1ps
module wdt_keyguard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_stb = 1'b0, halt_stb = 1'b0, low_power = 1'b0;
  logic       dev_rst, light_rst, to_flag;
  logic [7:0] rd_ctrl, rd_flags;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    bit    is_light;
    int    at;
    string tag;
  } evt_t;
  evt_t exp_q[$];

  always #2.5 clk = ~clk;

  wdt_keyguard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clr_stb(clr_stb), .halt_stb(halt_stb),
    .low_power(low_power), .dev_rst(dev_rst), .light_rst(light_rst),
    .to_flag(to_flag), .rd_ctrl(rd_ctrl), .rd_flags(rd_flags)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int tmo(input int n);
    return 256 << n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_evt(input bit light, input int at, input string tag);
    evt_t e;
    e.is_light = light; e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic handle_evt(input bit light);
    evt_t e;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL R2/R5/R6 unexpected reset light=%0d actual_cycle=%0d expected=none",
               light, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.is_light != light || e.at != cyc) begin
        failures++;
        $display("FAIL %s actual light=%0d cycle=%0d expected light=%0d cycle=%0d",
                 e.tag, light, cyc, e.is_light, e.at);
      end
    end
  endtask

  // Monitor: pop and compare on each rising reset output
  logic pd = 1'b0, pl = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_rst && !pd)   handle_evt(1'b0);
      if (light_rst && !pl) handle_evt(1'b1);
      pd = dev_rst;
      pl = light_rst;
    end
  end

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse(input bit use_halt);
    if (use_halt) halt_stb = 1'b1; else clr_stb = 1'b1;
    @(negedge clk);
    halt_stb = 1'b0; clr_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hang expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl during reset", rd_ctrl, 8'h50);
    rst_n = 1'b1;
    chk("R1 ctrl after reset", rd_ctrl, 8'h50);
    chk("R4 flags after reset", rd_flags, 8'h00);
    chk("R5 no status at reset", to_flag, 0);
    // R1 R5: free-running expiry
    push_evt(0, tmo(0), "R1 R5 first expiry");
    wait_to(tmo(0));
    chk("R5 status set", to_flag, 1);
    chk("R9 ctrl reloaded", rd_ctrl, 8'h50);
    chk("R4 timeout leaves swr clear", rd_flags, 8'h00);

    // R7: clear strobe restarts count and drops status
    wait_to(300);
    pulse(0);
    chk("R7 clr drops status", to_flag, 0);
    push_evt(0, 301 + tmo(0), "R7 clr restarts count");
    wait_to(301 + tmo(0));
    wait_to(600);
    chk("R7 status before halt", to_flag, 1);
    pulse(1);
    chk("R7 halt drops status", to_flag, 0);
    push_evt(0, 601 + tmo(0), "R7 halt restarts count");
    wait_to(601 + tmo(0));

    // R8: ratio 2
    wait_to(860);
    wr(0, 8'h52);
    chk("R8 ctrl readback", rd_ctrl, 8'h52);
    push_evt(0, 857 + tmo(2), "R8 ratio 2 time-out");
    wait_to(857 + tmo(2));
    chk("R9 ratio reloaded", rd_ctrl, 8'h50);

    // R2: disabled, then re-enabled
    wait_to(1900);
    wr(0, 8'hA8);
    chk("R2 ctrl readback", rd_ctrl, 8'hA8);
    wait_to(2600);
    chk("R2 no reset while disabled", dev_rst, 0);
    wr(0, 8'h50);
    push_evt(0, 2601 + tmo(0), "R1 R2 re-enabled expiry");
    wait_to(2601 + tmo(0));

    // R3: illegal key, then a write during the delay is ignored
    wait_to(2900);
    wr(0, 8'hF8);
    push_evt(0, 2901 + 4, "R3 delayed software reset");
    wr(0, 8'hA8);
    chk("R3 write ignored while pending", rd_ctrl, 8'hF8);
    wait_to(2905);
    chk("R4 swr flag set", rd_flags, 8'h01);
    chk("R9 ctrl reloaded after sw reset", rd_ctrl, 8'h50);
    chk("R9 status kept across reset", to_flag, 1);
    push_evt(0, 2905 + tmo(0), "R3 R5 count cleared by sw reset");

    // R4: write 1 keeps flag, write 0 clears
    wait_to(2910);
    wr(1, 8'hFD);
    chk("R4 write 1 no effect, bit2 written", rd_flags, 8'h05);
    wr(1, 8'h00);
    chk("R4 write 0 clears", rd_flags, 8'h00);
    wait_to(2905 + tmo(0));

    // R6: low-power expiry gives light reset only
    wait_to(3165);
    pulse(0);
    low_power = 1'b1;
    chk("R7 status dropped before sleep", to_flag, 0);
    push_evt(1, 3166 + tmo(0), "R6 light reset in sleep");
    wait_to(3166 + tmo(0));
    chk("R6 status set in sleep", to_flag, 1);
    chk("R6 ctrl untouched", rd_ctrl, 8'h50);
    low_power = 1'b0;
    push_evt(0, 3166 + 2 * tmo(0), "R5 run reset after wake");
    wait_to(3166 + 2 * tmo(0) + 10);
    chk("R5 R6 all expected resets seen", exp_q.size(), 0);
    finish_run();
  end
endmodule